// File: doc/BRIEF.md
# Preloaded Down-Counting Timer Core

This block is a down-counting timer. A free-running prescaler divides the input clock by (active prescale value + 1). Each prescaler output tick lowers the counter by one. When a tick finds the counter at zero, the counter wraps back to the active reload value. That wrap is called an underflow.

Software never writes the running configuration directly. It writes a preload copy of the prescale value and a preload copy of the reload value. The active (shadow) copies take those values only on an update event. An update event comes from an underflow or from a software update strobe.

Three controls shape the update behaviour:
- An update-disable input blocks every update event. While it is set, the counter and the prescaler still restart, but they use the values that are already active.
- An update-source select stops the software strobe from raising the update flag. Underflows still raise it.
- An auto-reload preload enable chooses whether a reload-value write waits for the next update or takes effect at once.

The update flag stays set until software clears it. The interrupt output is the flag gated by an interrupt enable.

Top module: `dtim_core`

## Requirements
- R1: After reset the counter is 0, the update flag and the interrupt are 0, the active prescale value is 0 and the active reload value equals the ARR_RST parameter (all ones by default).
- R2: While counting is enabled, the counter decrements once every (active prescale + 1) clock cycles. While counting is disabled and no update strobe arrives, the counter holds its value.
- R3: A tick that finds the counter at 0 is an underflow. On an underflow the counter loads the reload value, so one period lasts (reload + 1) ticks.
- R4: An underflow while update-disable is 0 copies both preload values into the active registers. The counter reloads from the new reload value in the same cycle, and the update flag is set.
- R5: An underflow while update-disable is 1 reloads the counter from the current active reload value. It leaves both active registers unchanged and does not set the update flag.
- R6: A software update strobe reloads the counter and restarts the prescaler at 0. When update-disable is 0, the strobe also loads both active registers from their preloads, and the counter takes the new reload value.
- R7: The strobe sets the update flag only when update-source select is 0. When update-source select is 1, the strobe still updates the active registers, and underflows still set the flag.
- R8: With auto-reload preload enable at 1, a reload-value write changes only the preload copy. With it at 0, the write reaches the active register on the next clock edge.
- R9: A prescale write changes only the preload copy. The active prescale value changes only on an update event.
- R10: The update flag stays set until a clear pulse arrives, and a new set wins over a clear in the same cycle. The interrupt output equals the flag ANDed with the interrupt enable.
- R11: A software update strobe while update-disable is 1 reloads the counter from the current active reload value. It leaves the active registers unchanged and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cntEnable | input | 1 | Counting enable |
| updDisable | input | 1 | Blocks all update events |
| updReqSrc | input | 1 | 1: software strobe does not set the update flag |
| arPreloadEn | input | 1 | 1: reload writes go to the preload copy only |
| irqEnable | input | 1 | Update interrupt enable |
| updGenStb | input | 1 | Software update strobe (one cycle) |
| flagClr | input | 1 | Clears the update flag |
| arrWrEn | input | 1 | Reload-value write strobe |
| arrWrData | input | CNT_W | Reload-value write data |
| pscWrEn | input | 1 | Prescale write strobe |
| pscWrData | input | PSC_W | Prescale write data |
| count | output | CNT_W | Current counter value |
| arrActive | output | CNT_W | Active reload value |
| pscActive | output | PSC_W | Active prescale value |
| updFlag | output | 1 | Update flag |
| irq | output | 1 | Update interrupt |

## Verification
The bench runs an underflow with update-disable set. A design that copied the new preload there would reload the counter with the pending value instead of the active one. The bench then sends a software strobe under update-source select. A design that ignored the select would raise a flag with no underflow, and one that gated the whole update would leave the active reload value stale. It also checks that the counter takes the new reload value in the very cycle of the update, which catches a one-period lag. Finally it checks that a prescale write waits for an update and that the prescaler restarts at zero after a strobe, which catches a tick arriving one cycle early.

// File: rtl/dtim_pkg.sv
package dtim_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;    // prescaler output pulse while counting
    logic reload;  // counter restarts (underflow or software strobe)
    logic update;  // shadow registers take preload values
  } dtimStrobes_t;

endpackage

// File: rtl/dtim_shadow_reg.sv
module dtim_shadow_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         direct,
  input  logic         update,
  output logic [W-1:0] preVal,
  output logic [W-1:0] actVal
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preVal <= RST_VAL;
    end else if (wrEn) begin
      preVal <= wrData;
    end
  end

  // A direct write wins; otherwise the active copy follows preload on update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actVal <= RST_VAL;
    end else if (wrEn && direct) begin
      actVal <= wrData;
    end else if (update) begin
      actVal <= preVal;
    end
  end

endmodule

// File: rtl/dtim_ctrl.sv
module dtim_ctrl
  import dtim_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEnable,
  input  logic             updDisable,
  input  logic             updReqSrc,
  input  logic             updGenStb,
  input  logic             flagClr,
  input  logic             irqEnable,
  input  logic [PSC_W-1:0] pscActive,
  input  logic             cntZero,
  output dtimStrobes_t     strobes,
  output logic             updFlag,
  output logic             irq
);

  logic [PSC_W-1:0] pscCnt;
  logic             tick;
  logic             underflow;
  logic             setFlag;

  assign tick      = cntEnable && (pscCnt == pscActive);
  assign underflow = tick && cntZero;
  assign setFlag   = !updDisable && (underflow || (updGenStb && !updReqSrc));

  always_comb begin
    strobes.tick   = tick;
    strobes.reload = underflow || updGenStb;
    strobes.update = !updDisable && (underflow || updGenStb);
  end

  // Prescaler counter: restarts on tick and on software strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pscCnt <= '0;
    end else if (updGenStb || tick) begin
      pscCnt <= '0;
    end else if (cntEnable) begin
      pscCnt <= pscCnt + 1'b1;
    end
  end

  // Update flag: set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      updFlag <= 1'b0;
    end else if (setFlag) begin
      updFlag <= 1'b1;
    end else if (flagClr) begin
      updFlag <= 1'b0;
    end
  end

  assign irq = updFlag && irqEnable;

endmodule

// File: rtl/dtim_datapath.sv
module dtim_datapath
  import dtim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dtimStrobes_t     strobes,
  input  logic             arPreloadEn,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] arrActive,
  output logic [PSC_W-1:0] pscActive,
  output logic             cntZero
);

  logic [CNT_W-1:0] arrPre;
  logic [PSC_W-1:0] pscPre;
  logic [CNT_W-1:0] loadVal;

  dtim_shadow_reg #(.W(CNT_W), .RST_VAL(ARR_RST)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (arrWrEn),
    .wrData (arrWrData),
    .direct (!arPreloadEn),
    .update (strobes.update),
    .preVal (arrPre),
    .actVal (arrActive)
  );

  dtim_shadow_reg #(.W(PSC_W), .RST_VAL('0)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (pscWrEn),
    .wrData (pscWrData),
    .direct (1'b0),
    .update (strobes.update),
    .preVal (pscPre),
    .actVal (pscActive)
  );

  // Active reload is refreshed before the counter reload: pick the preload on update
  assign loadVal = strobes.update ? arrPre : arrActive;
  assign cntZero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobes.reload) begin
      count <= loadVal;
    end else if (strobes.tick) begin
      count <= count - 1'b1;
    end
  end

  logic unusedPsc;
  assign unusedPsc = ^pscPre;

endmodule

// File: rtl/dtim_core.sv
module dtim_core
  import dtim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEnable,
  input  logic             updDisable,
  input  logic             updReqSrc,
  input  logic             arPreloadEn,
  input  logic             irqEnable,
  input  logic             updGenStb,
  input  logic             flagClr,
  input  logic             arrWrEn,
  input  logic [CNT_W-1:0] arrWrData,
  input  logic             pscWrEn,
  input  logic [PSC_W-1:0] pscWrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] arrActive,
  output logic [PSC_W-1:0] pscActive,
  output logic             updFlag,
  output logic             irq
);

  dtimStrobes_t strobes;
  logic         cntZero;

  dtim_ctrl #(.PSC_W(PSC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cntEnable  (cntEnable),
    .updDisable (updDisable),
    .updReqSrc  (updReqSrc),
    .updGenStb  (updGenStb),
    .flagClr    (flagClr),
    .irqEnable  (irqEnable),
    .pscActive  (pscActive),
    .cntZero    (cntZero),
    .strobes    (strobes),
    .updFlag    (updFlag),
    .irq        (irq)
  );

  dtim_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ARR_RST(ARR_RST)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .arPreloadEn (arPreloadEn),
    .arrWrEn     (arrWrEn),
    .arrWrData   (arrWrData),
    .pscWrEn     (pscWrEn),
    .pscWrData   (pscWrData),
    .count       (count),
    .arrActive   (arrActive),
    .pscActive   (pscActive),
    .cntZero     (cntZero)
  );

endmodule

// File: rtl/dtim_core_chk.sv
module dtim_core_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cntEnable,
  input logic             updDisable,
  input logic             updReqSrc,
  input logic             arPreloadEn,
  input logic             updGenStb,
  input logic             flagClr,
  input logic             arrWrEn,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] arrActive,
  input logic [PSC_W-1:0] pscActive,
  input logic             updFlag
);

  logic [CNT_W-1:0] countMinus;
  assign countMinus = count - 1'b1;

  // R2: idle counter holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEnable && !updGenStb) |=> $stable(count));

  // R2: a running nonzero counter steps down by at most one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEnable && !updGenStb && count != '0) |=>
      (count == $past(count) || count == $past(countMinus)));

  // R5: shadows frozen under update-disable
  p_udis_psc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    updDisable |=> $stable(pscActive));

  p_udis_arr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (updDisable && !(arrWrEn && !arPreloadEn)) |=> $stable(arrActive));

  // R5: no flag raised under update-disable
  p_udis_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (updDisable && !updFlag) |=> !updFlag);

  // R7: with source select set and no counting, nothing can raise the flag
  p_urs_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (updReqSrc && !cntEnable && !updFlag) |=> !updFlag);

  // R10: flag holds until cleared
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (updFlag && !flagClr) |=> updFlag);

endmodule

bind dtim_core dtim_core_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cntEnable   (cntEnable),
  .updDisable  (updDisable),
  .updReqSrc   (updReqSrc),
  .arPreloadEn (arPreloadEn),
  .updGenStb   (updGenStb),
  .flagClr     (flagClr),
  .arrWrEn     (arrWrEn),
  .count       (count),
  .arrActive   (arrActive),
  .pscActive   (pscActive),
  .updFlag     (updFlag)
);

// File: tb/tb_dtim_core.sv
module tb_dtim_core;

  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cntEnable = 1'b0, updDisable = 1'b0, updReqSrc = 1'b0;
  logic             arPreloadEn = 1'b1, irqEnable = 1'b0;
  logic             updGenStb = 1'b0, flagClr = 1'b0;
  logic             arrWrEn = 1'b0, pscWrEn = 1'b0;
  logic [CNT_W-1:0] arrWrData = '0;
  logic [PSC_W-1:0] pscWrData = '0;
  logic [CNT_W-1:0] count, arrActive;
  logic [PSC_W-1:0] pscActive;
  logic             updFlag, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtim_core dut (
    .clk(clk), .rst_n(rst_n), .cntEnable(cntEnable), .updDisable(updDisable),
    .updReqSrc(updReqSrc), .arPreloadEn(arPreloadEn), .irqEnable(irqEnable),
    .updGenStb(updGenStb), .flagClr(flagClr), .arrWrEn(arrWrEn),
    .arrWrData(arrWrData), .pscWrEn(pscWrEn), .pscWrData(pscWrData),
    .count(count), .arrActive(arrActive), .pscActive(pscActive),
    .updFlag(updFlag), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUg();
    updGenStb = 1'b1; step(1); updGenStb = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1; step(1); flagClr = 1'b0;
  endtask

  task automatic writeArr(input logic [CNT_W-1:0] v);
    arrWrData = v; arrWrEn = 1'b1; step(1); arrWrEn = 1'b0;
  endtask

  task automatic writePsc(input logic [PSC_W-1:0] v);
    pscWrData = v; pscWrEn = 1'b1; step(1); pscWrEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "count", 32'(count), 0);
    chk("R1", "flag", 32'(updFlag), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "arrActive", 32'(arrActive), 32'hFFFF);
    chk("R1", "pscActive", 32'(pscActive), 0);
  endtask

  task automatic testPreloadAndUg();
    arPreloadEn = 1'b1;
    writeArr(16'd5);
    chk("R8", "arr held in preload", 32'(arrActive), 32'hFFFF);
    pulseUg();
    chk("R6", "arrActive after strobe", 32'(arrActive), 5);
    chk("R6", "count after strobe", 32'(count), 5);
    chk("R7", "flag from strobe", 32'(updFlag), 1);
    pulseClr();
    chk("R10", "flag cleared", 32'(updFlag), 0);
    irqEnable = 1'b1;
    #1 chk("R10", "irq with flag low", 32'(irq), 0);
  endtask

  task automatic testCounting();
    cntEnable = 1'b1;
    step(3);
    chk("R2", "count after 3 ticks", 32'(count), 2);
    step(3);
    chk("R3", "count after underflow", 32'(count), 5);
    chk("R4", "flag on underflow", 32'(updFlag), 1);
    chk("R10", "irq follows flag", 32'(irq), 1);
    cntEnable = 1'b0;
    step(3);
    chk("R2", "count held while disabled", 32'(count), 5);
    pulseClr();
  endtask

  task automatic testUpdDisable();
    writeArr(16'd9);
    updDisable = 1'b1;
    cntEnable = 1'b1;
    step(6);
    chk("R5", "reload from active", 32'(count), 5);
    chk("R5", "arrActive frozen", 32'(arrActive), 5);
    chk("R5", "no flag", 32'(updFlag), 0);
    step(2);
    chk("R2", "count after 2 more", 32'(count), 3);
    cntEnable = 1'b0;
    pulseUg();
    chk("R11", "strobe reload from active", 32'(count), 5);
    chk("R11", "arrActive frozen", 32'(arrActive), 5);
    chk("R11", "no flag", 32'(updFlag), 0);
    updDisable = 1'b0;
  endtask

  task automatic testUrs();
    updReqSrc = 1'b1;
    pulseUg();
    chk("R7", "arrActive updated", 32'(arrActive), 9);
    chk("R7", "count reloaded", 32'(count), 9);
    chk("R7", "no flag from strobe", 32'(updFlag), 0);
    writeArr(16'd2);
    cntEnable = 1'b1;
    step(10);
    chk("R4", "count uses new reload", 32'(count), 2);
    chk("R4", "arrActive on underflow", 32'(arrActive), 2);
    chk("R7", "underflow still flags", 32'(updFlag), 1);
    cntEnable = 1'b0;
    pulseClr();
    updReqSrc = 1'b0;
  endtask

  task automatic testPrescale();
    writePsc(16'd2);
    chk("R9", "psc held in preload", 32'(pscActive), 0);
    pulseUg();
    chk("R9", "psc after strobe", 32'(pscActive), 2);
    chk("R6", "count after strobe", 32'(count), 2);
    pulseClr();
    cntEnable = 1'b1;
    step(2);
    chk("R2", "no tick before divide", 32'(count), 2);
    step(1);
    chk("R2", "tick on third cycle", 32'(count), 1);
    cntEnable = 1'b0;
  endtask

  task automatic testDirectArr();
    arPreloadEn = 1'b0;
    writeArr(16'd7);
    chk("R8", "direct write active", 32'(arrActive), 7);
    chk("R8", "count untouched", 32'(count), 1);
  endtask

  task automatic testFlagHold();
    pulseUg();
    chk("R6", "count from direct reload", 32'(count), 7);
    chk("R10", "flag set", 32'(updFlag), 1);
    step(5);
    chk("R10", "flag held", 32'(updFlag), 1);
    chk("R10", "irq high", 32'(irq), 1);
    irqEnable = 1'b0;
    #1 chk("R10", "irq masked", 32'(irq), 0);
    pulseClr();
    chk("R10", "flag cleared", 32'(updFlag), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    testReset();
    testPreloadAndUg();
    testCounting();
    testUpdDisable();
    testUrs();
    testPrescale();
    testDirectArr();
    testFlagHold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule